// File: doc/BRIEF.md
# Split-Byte Dual PWM Digital-to-Analog Converter

This block turns a 16-bit audio sample into two pulse-width-modulated pins. The sample is cut into two bytes: the upper byte sets the duty cycle of one channel and the lower byte sets the duty cycle of the other. Outside the chip, the two pins are weighted, summed and low-pass filtered so the lower-byte channel adds fine detail beneath the upper-byte channel. That network is not part of this block.

Both channels share one free-running 8-bit counter, so their periods stay phase-aligned. At the intended 24 MHz clock one period is 256 clocks, or 93.75 kHz. A new sample is taken on a valid strobe into a holding register. It reaches the comparators only when the counter wraps from 255 to 0, so no pulse is ever cut short or stretched in the middle. Signed samples are moved to offset binary by flipping the sign bit before the split, which puts zero at mid-scale.

Top module: `split_pwm_dac`

## Requirements
- R1: While `rst` is high, both bits of `pwm_out` are low. The first period after reset runs with both duty values at 0 and starts at counter value 0.
- R2: Both channels use one counter that counts 0 to 255 and then wraps. Each period is exactly 256 clocks long, and a channel with a nonzero duty rises at the start of every period.
- R3: `pwm_out[1]` is high while the counter is strictly less than bits 15:8 of the converted sample. It is therefore high for that many clocks of each period.
- R4: `pwm_out[0]` is high while the counter is strictly less than bits 7:0 of the converted sample. It is therefore high for that many clocks of each period.
- R5: A duty byte of 0 keeps its pin low for the whole period. A duty byte of 255 keeps it high for 255 of the 256 clocks.
- R6: A sample strobed in the middle of a period does not change either pin until the counter next wraps from 255 to 0. From that period on, both channels use the new bytes.
- R7: If several samples are strobed within one period, only the last one is used in the next period.
- R8: A sample strobed on the clock edge where the counter wraps from 255 to 0 does not take effect in the period that edge starts. It takes effect one period later.
- R9: When `smp_in_signed` is 1 at the strobe, bit 15 of the sample is inverted before the split. For example, 0x0000 gives duties 128 and 0, and 0xFFFF gives 127 and 255.
- R10: When `smp_in_signed` is 0 at the strobe, the sample is split unchanged.
- R11: Changes on `smp_data` or `smp_in_signed` while `smp_valid` is low have no effect on either pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock (24 MHz intended) |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe: capture `smp_data` this cycle |
| smp_in_signed | input | 1 | 1: sample is two's complement; 0: offset binary |
| smp_data | input | 16 | Audio sample |
| pwm_out | output | 2 | Bit 1: upper-byte channel; bit 0: lower-byte channel |

## Verification
The hardest case to reach from the ports is a strobe on the exact clock edge where the counter wraps from 255 to 0. At that edge the holding register is being written at the same time as the active duty values are being loaded. The bench keeps its own model of the counter phase, waits until that model shows 255, and raises the strobe for exactly that edge. It then measures the high time over the next two full periods separately. The same phase tracking is used to place a pair of strobes inside a single period and a strobe in the middle of a period.

// File: rtl/split_pwm_dac_pkg.sv
package split_pwm_dac_pkg;

    // Default geometry of the converter
    localparam int unsigned SAMPLE_BITS = 16;
    localparam int unsigned SLICE_BITS  = 8;
    localparam int unsigned SLICE_COUNT = SAMPLE_BITS / SLICE_BITS;

    typedef logic [SAMPLE_BITS-1:0] sample_t;
    typedef logic [SLICE_BITS-1:0]  slice_t;

    // Captured sample together with its number format
    typedef struct packed {
        logic    is_signed;
        sample_t data;
    } sample_beat_t;

    // Flip the sign bit so two's complement zero lands on mid-scale
    function automatic sample_t to_offset_binary(input sample_beat_t beat);
        sample_t r;
        r = beat.data;
        r[SAMPLE_BITS-1] = beat.data[SAMPLE_BITS-1] ^ beat.is_signed;
        return r;
    endfunction

endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LAST_VAL = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

    // High during the final clock of a period; the next edge wraps
    assign at_last = (count == LAST_VAL);
endmodule

// File: rtl/pwm_duty_bank.sv
module pwm_duty_bank
    import split_pwm_dac_pkg::*;
#(
    parameter int unsigned SAMPLE_W = SAMPLE_BITS,
    parameter int unsigned SLICE_W  = SLICE_BITS,
    parameter int unsigned NUM_CH   = SAMPLE_W / SLICE_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           strobe,
    input  logic                           in_signed,
    input  logic [SAMPLE_W-1:0]            data_in,
    input  logic                           period_end,
    output logic [NUM_CH-1:0][SLICE_W-1:0] shadow_slices,
    output logic [NUM_CH-1:0][SLICE_W-1:0] active_slices
);
    logic [SAMPLE_W-1:0] converted;

    always_comb begin
        converted = data_in;
        converted[SAMPLE_W-1] = data_in[SAMPLE_W-1] ^ in_signed;
    end

    // Holding register: written on every strobe, last one wins
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_slices <= '0;
        end else if (strobe) begin
            shadow_slices <= converted;
        end
    end

    // Active duty values: copied only on the wrap edge, per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_active
        always_ff @(posedge clk) begin
            if (rst) begin
                active_slices[ch] <= '0;
            end else if (period_end) begin
                active_slices[ch] <= shadow_slices[ch];
            end
        end
    end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] duty,
    output logic             level
);
    assign level = (count < duty);
endmodule

// File: rtl/split_pwm_dac.sv
module split_pwm_dac
    import split_pwm_dac_pkg::*;
#(
    parameter int unsigned SAMPLE_W = SAMPLE_BITS,
    parameter int unsigned SLICE_W  = SLICE_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_valid,
    input  logic                  smp_in_signed,
    input  logic [SAMPLE_W-1:0]   smp_data,
    output logic [SAMPLE_W/SLICE_W-1:0] pwm_out
);
    localparam int unsigned NUM_CH = SAMPLE_W / SLICE_W;

    logic [SLICE_W-1:0]             cnt_q;
    logic                           wrap_now;
    logic [NUM_CH-1:0][SLICE_W-1:0] shadow_s;
    logic [NUM_CH-1:0][SLICE_W-1:0] duty_s;
    logic [NUM_CH-1:0]              level_s;

    pwm_period_counter #(.CNT_W(SLICE_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .count   (cnt_q),
        .at_last (wrap_now)
    );

    pwm_duty_bank #(
        .SAMPLE_W (SAMPLE_W),
        .SLICE_W  (SLICE_W),
        .NUM_CH   (NUM_CH)
    ) u_bank (
        .clk           (clk),
        .rst           (rst),
        .strobe        (smp_valid),
        .in_signed     (smp_in_signed),
        .data_in       (smp_data),
        .period_end    (wrap_now),
        .shadow_slices (shadow_s),
        .active_slices (duty_s)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pwm_compare #(.CNT_W(SLICE_W)) u_cmp (
            .count (cnt_q),
            .duty  (duty_s[ch]),
            .level (level_s[ch])
        );
    end

    // Pins are forced low throughout reset
    assign pwm_out = rst ? '0 : level_s;
endmodule

// File: rtl/split_pwm_dac_chk.sv
module split_pwm_dac_chk #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned NUM_CH = 2
) (
    input logic                         clk,
    input logic                         rst,
    input logic [CNT_W-1:0]             cnt,
    input logic                         wrap,
    input logic [NUM_CH-1:0][CNT_W-1:0] shadow,
    input logic [NUM_CH-1:0][CNT_W-1:0] duty,
    input logic [NUM_CH-1:0]            pwm
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R1: pins held low in reset
    always @(negedge clk) begin
        if (rst) assert_quiet_in_reset_R1: assert (pwm == '0);
    end

    // R2: counter steps by one every clock and wraps
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt == CNT_W'($past(cnt) + 1'b1));

    // R6: duty registers move only after a wrap edge
    assert_duty_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wrap)) |-> $stable(duty));

    // R7 R8: at the wrap the holding register content becomes active
    assert_duty_load_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wrap)) |-> duty == $past(shadow));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pin
        // R5: zero duty never drives high
        assert_zero_low_R5: assert property (@(posedge clk) disable iff (rst)
            (duty[ch] == '0) |-> !pwm[ch]);
        // R5: last clock of a period is always low
        assert_last_low_R5: assert property (@(posedge clk) disable iff (rst)
            (cnt == TOP) |-> !pwm[ch]);
        // R2: nonzero duty is high at period start
        assert_start_high_R2: assert property (@(posedge clk) disable iff (rst)
            (cnt == '0 && duty[ch] != '0) |-> pwm[ch]);
    end
endmodule

bind split_pwm_dac split_pwm_dac_chk #(
    .CNT_W  (SLICE_W),
    .NUM_CH (NUM_CH)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt    (cnt_q),
    .wrap   (wrap_now),
    .shadow (shadow_s),
    .duty   (duty_s),
    .pwm    (pwm_out)
);

// File: tb/tb_split_pwm_dac.sv
module tb_split_pwm_dac;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic        smp_in_signed = 1'b0;
    logic [15:0] smp_data = 16'h0000;
    logic [1:0]  pwm_out;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    string cur_req = "R1";

    // Behavioural reference state
    int m_cnt = 0;
    int m_hold = 0;
    int m_act = 0;

    always #5 clk = ~clk;

    split_pwm_dac dut (
        .clk           (clk),
        .rst           (rst),
        .smp_valid     (smp_valid),
        .smp_in_signed (smp_in_signed),
        .smp_data      (smp_data),
        .pwm_out       (pwm_out)
    );

    always @(posedge clk) begin
        int nxt_hold;
        nxt_hold = m_hold;
        if (rst) begin
            m_cnt = 0; m_hold = 0; m_act = 0;
        end else begin
            if (smp_valid)
                nxt_hold = smp_in_signed ? (int'(smp_data) ^ 32'h8000) : int'(smp_data);
            if (m_cnt == 255) m_act = m_hold;
            m_hold = nxt_hold;
            m_cnt = (m_cnt + 1) % 256;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare against the model on every clock
    always @(negedge clk) begin
        if (!finished) begin
            int exp_v;
            if (rst) exp_v = 0;
            else exp_v = {(m_cnt < ((m_act >> 8) & 255)) ? 1'b1 : 1'b0,
                          (m_cnt < (m_act & 255)) ? 1'b1 : 1'b0};
            check(cur_req, int'(pwm_out), exp_v);
        end
    end

    task automatic wait_cnt(input int k);
        while (m_cnt != k) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] d, input logic sg);
        smp_data = d; smp_in_signed = sg; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Count high clocks of each pin over one whole period
    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        wait_cnt(0);
        for (int i = 0; i < 256; i++) begin
            hi += pwm_out[1];
            lo += pwm_out[0];
            @(negedge clk);
        end
    endtask

    int watchdog = 0;
    always @(negedge clk) begin
        watchdog++;
        if (watchdog > 100000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=done", watchdog);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int h, l, gap;
        repeat (5) @(negedge clk);
        check("R1", int'(pwm_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", m_cnt, 1);

        // R6: mid-period strobe waits for the wrap
        cur_req = "R6";
        wait_cnt(100);
        send(16'hC040, 1'b0);
        check("R6", int'(pwm_out), 0);
        wait_cnt(255);
        check("R6", int'(pwm_out), 0);
        cur_req = "R3 R4 R10";
        measure(h, l);
        check("R3", h, 192);
        check("R4", l, 64);
        check("R10", h * 256 + l, 16'hC040 >> 8 << 8 | 64);

        // R2: rising edges of the upper channel are 256 clocks apart
        cur_req = "R2";
        wait_cnt(0);
        @(negedge clk);
        gap = 1;
        while (!(pwm_out[1] && m_cnt == 0)) begin @(negedge clk); gap++; end
        check("R2", gap, 256);

        // R5: extremes
        cur_req = "R5";
        send(16'hFF00, 1'b0);
        measure(h, l);
        measure(h, l);
        check("R5", h, 255);
        check("R5", l, 0);

        // R7: last strobe in a period wins
        cur_req = "R7";
        wait_cnt(20);
        send(16'h1122, 1'b0);
        wait_cnt(200);
        send(16'h3344, 1'b0);
        measure(h, l);
        check("R7", h, 8'h33);
        check("R7", l, 8'h44);

        // R8: strobe on the wrap edge lands one period later
        cur_req = "R8";
        wait_cnt(255);
        send(16'h0A0B, 1'b0);
        measure(h, l);
        check("R8", h, 8'h33);
        check("R8", l, 8'h44);
        measure(h, l);
        check("R8", h, 8'h0A);
        check("R8", l, 8'h0B);

        // R9: signed inputs
        cur_req = "R9";
        send(16'h0000, 1'b1);
        measure(h, l);
        measure(h, l);
        check("R9", h, 128);
        check("R9", l, 0);
        send(16'hFFFF, 1'b1);
        measure(h, l);
        measure(h, l);
        check("R9", h, 127);
        check("R9", l, 255);

        // R11: data moves without a strobe
        cur_req = "R11";
        wait_cnt(10);
        smp_data = 16'h1234; smp_in_signed = 1'b0;
        repeat (300) begin
            @(negedge clk);
            smp_data = smp_data + 16'h0101;
            smp_in_signed = ~smp_in_signed;
        end
        measure(h, l);
        check("R11", h, 127);
        check("R11", l, 255);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule